// File: doc/BRIEF.md
# Serial PHY Management Master

This block runs single register transactions against an external Ethernet PHY over the two-wire clause-22 management bus. A host presents one request at a time: read or write, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block then generates the whole serial frame on its own. It drives the management clock and controls the shared data line through separate output, input and output-enable pins, so a pad cell or a tristate buffer can be placed outside it.

The management clock runs only while a transaction is in flight. Its half period is set by the `clk_div` input, which counts system clock cycles. A completed transaction raises `done` for one cycle. After a read, `rd_data` holds the value that was sampled. A read whose PHY does not pull the line low in the acknowledge slot still runs through every clock of the data phase, so that every PHY on the bus stays aligned with the frame. The block then returns zero and sets `ack_err`.

Top module: `mgmt_serial_master`

## Requirements
- R1: After reset, `busy`, `done`, `mdc`, `mdio_oe` and `mdio_o` are all low.
- R2: Each frame has 65 bit periods, numbered 0 to 64. Periods 0-31 carry ones. Periods 32-33 carry 0,1. Periods 34-35 carry the opcode: 1,0 for a read (`req_write`=0) and 0,1 for a write. Periods 36-40 carry the PHY address and periods 41-45 the register address, both MSB first.
- R3: In a write, periods 46-47 carry 1,0, periods 48-63 carry `req_wdata` MSB first, and period 64 is driven low. `mdio_oe` stays high through period 64 and is low afterwards. A write ends with `rd_data`=0 and `ack_err`=0.
- R4: In a read, `mdio_oe` is high for periods 0-45 and low from period 46 on. The acknowledge level is taken at the rising `mdc` edge of period 47. Data is taken at the rising edges of periods 48-63, MSB first.
- R5: In a read where `mdio_i` is high in period 47 (no acknowledge), the frame still has all 65 clock periods. At `done`, `rd_data`=0 and `ack_err`=1.
- R6: In an acknowledged read, `rd_data` equals the 16 sampled bits at `done` and `ack_err` is 0.
- R7: `mdio_o` and `mdio_oe` change only together with a falling `mdc` edge. Each `mdc` phase lasts `clk_div`+1 system cycles.
- R8: `busy` is high from the cycle a request is accepted for exactly 130*(`clk_div`+1) cycles. `done` pulses for one cycle as `busy` falls.
- R9: A `req_valid` pulse while `busy` is high starts nothing and does not change the frame in progress.
- R10: While idle, `mdc` stays low and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | Management clock half period minus one, in system cycles |
| req_valid | input | 1 | Start a transaction when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | Transaction in flight |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid from `done` |
| ack_err | output | 1 | Last read was not acknowledged |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
If the bit index or the shift register slips, the frame that a PHY model captures on rising `mdc` edges shows it: a field lands one period early or late, the release point moves, or the frame no longer has exactly 65 rising edges. That is visible within the transaction. A divider fault appears as a wrong `busy` length at the end of the frame. A stale acknowledge or capture register appears at the next `done` as the wrong `rd_data` or `ack_err`. The bench sweeps three divider values, both opcodes, acknowledged and unacknowledged reads, and a request made in the middle of a frame.

// File: rtl/msm_pkg.sv
package msm_pkg;
  localparam int PRE_LEN   = 32;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 2*ADDR_W + 2 + DATA_W + 1;
  localparam int IDX_W     = $clog2(FRAME_LEN + 1);
  localparam int DRV_RD    = PRE_LEN + 4 + 2*ADDR_W;   // driven periods of a read
  localparam int ACK_IDX   = DRV_RD + 1;
  localparam int DAT_FIRST = ACK_IDX + 1;
  localparam int DAT_LAST  = DAT_FIRST + DATA_W - 1;
  localparam int LAST_IDX  = FRAME_LEN - 1;

  typedef struct packed {
    logic [FRAME_LEN-1:0] bits;
    logic [FRAME_LEN-1:0] oe;
  } frame_t;

  // Whole frame, first period in the MSB.
  function automatic frame_t build_frame(input logic wr,
                                         input logic [ADDR_W-1:0] pa,
                                         input logic [ADDR_W-1:0] ra,
                                         input logic [DATA_W-1:0] wd);
    frame_t f;
    f.bits = {{PRE_LEN{1'b1}}, 2'b01, (wr ? 2'b01 : 2'b10), pa, ra,
              (wr ? 2'b10 : 2'b00), (wr ? wd : {DATA_W{1'b0}}), 1'b0};
    if (wr) f.oe = {FRAME_LEN{1'b1}};
    else    f.oe = {{DRV_RD{1'b1}}, {(FRAME_LEN-DRV_RD){1'b0}}};
    return f;
  endfunction
endpackage

// File: rtl/msm_clkgen.sv
module msm_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             term;

  assign term = run && (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (term) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_stb = term & ~mdc_q;
  assign fall_stb = term &  mdc_q;
endmodule

// File: rtl/msm_seq.sv
module msm_seq
  import msm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              ack_err,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic                 busy_q, busy_d;
  logic                 done_q, done_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [FRAME_LEN-1:0] out_q, out_d;
  logic [FRAME_LEN-1:0] oe_q, oe_d;
  logic                 wr_q, wr_d;
  logic                 nack_q, nack_d;
  logic [DATA_W-1:0]    shf_q, shf_d;
  logic [DATA_W-1:0]    rd_q, rd_d;
  logic                 err_q, err_d;
  logic                 start;
  frame_t               fr;

  assign start = req_valid & ~busy_q;
  assign fr    = build_frame(req_write, req_phy, req_reg, req_wdata);

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    idx_d  = idx_q;
    out_d  = out_q;
    oe_d   = oe_q;
    wr_d   = wr_q;
    nack_d = nack_q;
    shf_d  = shf_q;
    rd_d   = rd_q;
    err_d  = err_q;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
      out_d  = fr.bits;
      oe_d   = fr.oe;
      wr_d   = req_write;
      nack_d = 1'b0;
      shf_d  = '0;
    end else if (busy_q) begin
      if (rise_stb && !wr_q) begin
        if (idx_q == IDX_W'(ACK_IDX))
          nack_d = mdio_i;
        else if (idx_q >= IDX_W'(DAT_FIRST) && idx_q <= IDX_W'(DAT_LAST))
          shf_d = {shf_q[DATA_W-2:0], mdio_i};
      end
      if (fall_stb) begin
        if (idx_q == IDX_W'(LAST_IDX)) begin
          busy_d = 1'b0;
          done_d = 1'b1;
          rd_d   = (wr_q || nack_q) ? '0 : shf_q;
          err_d  = ~wr_q & nack_q;
        end else begin
          idx_d = idx_q + 1'b1;
          out_d = out_q << 1;
          oe_d  = oe_q << 1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      out_q  <= '0;
      oe_q   <= '0;
      wr_q   <= 1'b0;
      nack_q <= 1'b0;
      shf_q  <= '0;
      rd_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
      out_q  <= out_d;
      oe_q   <= oe_d;
      wr_q   <= wr_d;
      nack_q <= nack_d;
      shf_q  <= shf_d;
      rd_q   <= rd_d;
      err_q  <= err_d;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rd_data = rd_q;
  assign ack_err = err_q;
  assign mdio_oe = busy_q & oe_q[FRAME_LEN-1];
  assign mdio_o  = busy_q & oe_q[FRAME_LEN-1] & out_q[FRAME_LEN-1];
endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [4:0]       req_phy,
  input  logic [4:0]       req_reg,
  input  logic [15:0]      req_wdata,
  output logic             busy,
  output logic             done,
  output logic [15:0]      rd_data,
  output logic             ack_err,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic rise_stb, fall_stb;

  msm_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .div      (clk_div),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  msm_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_phy   (req_phy),
    .req_reg   (req_reg),
    .req_wdata (req_wdata),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb),
    .mdio_i    (mdio_i),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data),
    .ack_err   (ack_err),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );
endmodule

// File: rtl/msm_chk.sv
module msm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic [15:0] rd_data,
  input logic        ack_err,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe && !mdio_o));

  a_r7_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  a_r5_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |-> (rd_data == 16'h0000));
endmodule

bind mgmt_serial_master msm_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .rd_data (rd_data),
  .ack_err (ack_err),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe)
);

// File: tb/mgmt_serial_master_tb_top.sv
module mgmt_serial_master_tb_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] clk_div = '0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]    req_phy = '0, req_reg = '0;
  logic [15:0]   req_wdata = '0;
  logic          busy, done, ack_err, mdc, mdio_o, mdio_oe;
  logic [15:0]   rd_data;
  logic          mdio_i = 1'b1;

  always #5 clk = ~clk;

  mgmt_serial_master #(.DIV_W(DW)) dut_i (.*);

  int checks = 0, fails = 0;
  int rise_total = 0, base = 0, busy_total = 0, done_total = 0;
  int rel, nxt;
  logic smp_o [0:127];
  logic smp_oe[0:127];
  logic prev_mdc = 1'b0;
  logic ph_read = 1'b0, ph_ack = 1'b0;
  logic [15:0] ph_data = '0;

  // PHY responder: captures at rising mdc, drives after falling mdc
  always @(negedge clk) begin
    if (busy) busy_total++;
    if (done) done_total++;
    if (mdc && !prev_mdc) begin
      rel = rise_total - base;
      if (rel >= 0 && rel < 128) begin
        smp_o[rel]  = mdio_o;
        smp_oe[rel] = mdio_oe;
      end
      rise_total++;
    end
    if (!mdc && prev_mdc) begin
      nxt = rise_total - base;
      if (!ph_read) mdio_i = 1'b1;
      else if (nxt == 47) mdio_i = ph_ack ? 1'b0 : 1'b1;
      else if (nxt >= 48 && nxt <= 63) mdio_i = ph_ack ? ph_data[63-nxt] : 1'b1;
      else mdio_i = 1'b1;
    end
    if (!busy) mdio_i = 1'b1;
    prev_mdc = mdc;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input logic wr, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input int dv, input bit ack,
                         input logic [15:0] pdata, input bit inject);
    logic [64:0] eo, eoe;
    int b0, d0, bad_o, bad_oe, first_o, first_oe;
    clk_div = DW'(dv);
    ph_read = ~wr;
    ph_ack  = ack;
    ph_data = pdata;
    @(negedge clk);
    base = rise_total; b0 = busy_total; d0 = done_total;
    req_write = wr; req_phy = pa; req_reg = ra; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (inject) begin
      repeat (100) @(negedge clk);
      req_write = ~wr; req_phy = ~pa; req_reg = ~ra; req_wdata = ~wd; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    if (wr) begin
      check(rd_data == 16'h0 && !ack_err, "R3", "write result", {rd_data, ack_err}, 0);
    end else if (ack) begin
      check(rd_data == pdata, "R6", "read data", rd_data, pdata);
      check(!ack_err, "R6", "ack_err", ack_err, 0);
    end else begin
      check(rd_data == 16'h0, "R5", "nack data", rd_data, 0);
      check(ack_err, "R5", "ack_err", ack_err, 1);
    end
    repeat (20) @(negedge clk);
    // expected frame, period k at bit 64-k
    eo  = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), pa, ra,
           (wr ? 2'b10 : 2'b00), (wr ? wd : 16'h0), 1'b0};
    eoe = wr ? {65{1'b1}} : {{46{1'b1}}, {19{1'b0}}};
    bad_o = 0; bad_oe = 0; first_o = -1; first_oe = -1;
    for (int k = 0; k < 65; k++) begin
      if (smp_oe[k] !== eoe[64-k]) begin bad_oe++; if (first_oe < 0) first_oe = k; end
      if (eoe[64-k] && smp_o[k] !== eo[64-k]) begin bad_o++; if (first_o < 0) first_o = k; end
    end
    check(bad_o == 0, wr ? "R3" : "R2", "data bits, first bad period", first_o, -1);
    check(bad_oe == 0, wr ? "R3" : "R4", "enable, first bad period", first_oe, -1);
    check(rise_total - base == 65, "R5", "rising edge count", rise_total - base, 65);
    check(busy_total - b0 == 130*(dv+1), "R8", "busy cycles", busy_total - b0, 130*(dv+1));
    check(done_total - d0 == 1, inject ? "R9" : "R8", "done pulses", done_total - d0, 1);
    check(!busy && !mdc && !mdio_oe, "R10", "idle after frame", {busy, mdc, mdio_oe}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !mdc && !mdio_oe && !mdio_o, "R1", "reset outputs",
          {busy, done, mdc, mdio_oe, mdio_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !mdc && !mdio_oe, "R10", "idle before first request", {busy, mdc, mdio_oe}, 0);
    for (int d = 0; d < 3; d++) begin
      for (int t = 0; t < 4; t++) begin
        int dv = (d == 2) ? 3 : d;
        logic [4:0]  pa = 5'((t * 7 + d) % 32);
        logic [4:0]  ra = 5'((31 - t * 9 + d) % 32);
        logic [15:0] wd = 16'((t * 16'h3A5D + d * 16'h1111) ^ 16'h8001);
        run_txn(1'b1, pa, ra, wd, dv, 1'b0, 16'h0, 1'b0);          // R3 write
        run_txn(1'b0, pa, ra, 16'h0, dv, 1'b1, ~wd, 1'b0);          // R4 R6 acked read
        run_txn(1'b0, ra, pa, 16'h0, dv, 1'b0, wd, 1'b0);           // R5 no ack
      end
    end
    run_txn(1'b0, 5'h1F, 5'h00, 16'h0, 1, 1'b1, 16'h0000, 1'b0);
    run_txn(1'b0, 5'h00, 5'h1F, 16'h0, 1, 1'b1, 16'hFFFF, 1'b0);
    run_txn(1'b1, 5'h15, 5'h0A, 16'hA5A5, 1, 1'b0, 16'h0, 1'b1);    // R9 write hit mid-frame
    run_txn(1'b0, 5'h0A, 5'h15, 16'h0, 2, 1'b1, 16'h5AC3, 1'b1);    // R9 read hit mid-frame
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule